// File: doc/BRIEF.md
# Capture Relay Timer

This block is a two-channel timer peripheral whose input-capture path carries an interrupt from another unit to a processor interrupt line. A bank of external event inputs is synchronized. One shared select register then gives each capture channel its own source. Each channel runs its own free-running counter and watches its chosen event for a rising or a falling transition. On a qualifying transition the channel stores the count and sets a capture status flag. The count itself carries no meaning in this use; the flag and the interrupt it drives are what matter.

Software programs the source selection, edge polarity, capture mode and interrupt enable over a simple register bus. Writes take effect on the next clock edge. Reads are combinational from the stored state. The interrupt service routine acknowledges an event by writing 1 to the status bit. Detection is edge-based, so a source that stays high after its flag is cleared does not raise the interrupt again. A new interrupt needs the source to drop and then rise again.

Register map (byte addresses): the select register is at 0x00. Channel c has its base at 0x10 + 0x20*c. Within a channel, the control register is at +0x00, status at +0x04, enable-set at +0x08, enable-clear at +0x0C and the captured count at +0x10. Unmapped addresses read as zero.

Top module: `relay_capture_timer`

## Requirements
- R1: The select register at 0x00 holds one 8-bit field per channel: bits [7:0] choose the event for channel 0 and bits [15:8] the event for channel 1. Writing 0x908 routes event 8 to channel 0 and event 9 to channel 1, and the register reads back the written value.
- R2: A select field whose value is not below the number of event inputs (16 by default) selects a constant 0, so that channel never captures.
- R3: Control bit 8 picks the edge: 1 captures on rising transitions of the selected event, 0 on falling ones. Control bit 13 picks the mode. The control register reads back bits 13 and 8 and resets to 0.
- R4: An event transition applied between clock edges sets the channel's flag on the third rising clock edge that follows. The same edge stores the channel counter into the capture register.
- R5: A selected event that stays at its active level produces no further capture after its flag is cleared, until it leaves that level and returns.
- R6: With control bit 13 at 0 (single capture), a channel whose flag is set ignores further edges: the capture register and the flag keep their values until the flag is cleared.
- R7: With control bit 13 at 1 (multi capture), every qualifying edge reloads the capture register and sets the flag again, even while the flag is already set.
- R8: The flag reads as bit 2 of the status register. Writing 1 to that bit clears the flag on the next edge. Writing 0 leaves it unchanged.
- R9: A clear write on the same clock edge as a new capture leaves the flag set.
- R10: Writing 1 to bit 2 of the enable-set register sets the channel's interrupt enable. Writing 1 to bit 2 of the enable-clear register clears it. Both registers read the enable in bit 2.
- R11: A channel's interrupt output is high exactly while both its flag and its enable are set.
- R12: After reset every register reads 0 and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_EVENTS | Asynchronous external event lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for both read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_o | output | NUM_CH | Per-channel interrupt request |

## Verification
An event change takes three rising edges to reach the flag and the interrupt: two synchronizer stages, then the edge register and flag update together. A register write shows up one edge later, and a read returns the current state at once. The bench changes inputs only on falling clock edges. It samples flags and interrupts on the third falling edge after an event change, and it reads registers one delta after it sets the address. The same-edge race between a clear and a capture is hit on purpose: the clear write is issued two falling edges after the event rises, so both reach the flag on one rising edge.

// File: rtl/relay_pkg.sv
package relay_pkg;

    // address layout
    localparam int EVSEL_OFS = 0;
    localparam int CH_BASE   = 16;
    localparam int CH_STRIDE = 32;
    localparam int OFS_CTRL  = 0;
    localparam int OFS_STAT  = 4;
    localparam int OFS_ENSET = 8;
    localparam int OFS_ENCLR = 12;
    localparam int OFS_CAPT  = 16;

    // bit positions inside channel registers
    localparam int BIT_EDGE  = 8;
    localparam int BIT_MODE  = 13;
    localparam int BIT_FLAG  = 2;

    function automatic int chan_addr(input int ch, input int ofs);
        return CH_BASE + CH_STRIDE * ch + ofs;
    endfunction

endpackage

// File: rtl/relay_sync2.sv
module relay_sync2 #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/relay_evmux.sv
module relay_evmux #(
    parameter int NUM_EVENTS = 16,
    parameter int SEL_W      = 8
) (
    input  logic [NUM_EVENTS-1:0] ev_sync_i,
    input  logic [SEL_W-1:0]      sel_i,
    output logic                  ev_o
);

    // selects past the last input fall through to constant 0
    always_comb begin
        ev_o = 1'b0;
        for (int i = 0; i < NUM_EVENTS; i++) begin
            if (sel_i == SEL_W'(i)) ev_o = ev_sync_i[i];
        end
    end

endmodule

// File: rtl/relay_capt_chan.sv
module relay_capt_chan #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_i,
    input  logic               ctrl_we,
    input  logic               ctrl_rise,
    input  logic               ctrl_multi,
    input  logic               clr_req,
    input  logic               enset_req,
    input  logic               enclr_req,
    output logic               rise_o,
    output logic               multi_o,
    output logic               flag_o,
    output logic               en_o,
    output logic               fire_o,
    output logic               irq_o,
    output logic [COUNT_W-1:0] capt_o
);

    typedef struct packed {
        logic [COUNT_W-1:0] cnt;
        logic [COUNT_W-1:0] capt;
        logic               prev;
        logic               rise;
        logic               multi;
        logic               flag;
        logic               en;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     edge_hit;
    logic     fire;

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = st_q.cnt + 1'b1;
        st_d.prev = ev_i;

        edge_hit = st_q.rise ? (ev_i & ~st_q.prev) : (~ev_i & st_q.prev);
        // single mode holds off while the previous capture is unacknowledged
        fire     = edge_hit & (st_q.multi | ~st_q.flag);

        if (ctrl_we) begin
            st_d.rise  = ctrl_rise;
            st_d.multi = ctrl_multi;
        end

        // a capture wins over a same-edge acknowledge
        if (fire) begin
            st_d.capt = st_q.cnt;
            st_d.flag = 1'b1;
        end else if (clr_req) begin
            st_d.flag = 1'b0;
        end

        if (enclr_req)      st_d.en = 1'b0;
        else if (enset_req) st_d.en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o  = st_q.rise;
    assign multi_o = st_q.multi;
    assign flag_o  = st_q.flag;
    assign en_o    = st_q.en;
    assign fire_o  = fire;
    assign irq_o   = st_q.flag & st_q.en;
    assign capt_o  = st_q.capt;

endmodule

// File: rtl/relay_capture_timer.sv
module relay_capture_timer
    import relay_pkg::*;
#(
    parameter int NUM_EVENTS = 16,
    parameter int NUM_CH     = 2,
    parameter int SEL_W      = 8,
    parameter int COUNT_W    = 32,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] evt_in,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_CH-1:0]     irq_o
);

    localparam int EVSEL_W = NUM_CH * SEL_W;

    typedef struct packed {
        logic [EVSEL_W-1:0] evsel;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_EVENTS-1:0]          ev_sync;
    logic [NUM_CH-1:0][SEL_W-1:0]   ch_sel;
    logic [NUM_CH-1:0]              ch_ev;
    logic [NUM_CH-1:0]              ch_fire;
    logic [NUM_CH-1:0]              ch_flag;
    logic [NUM_CH-1:0]              ch_en;
    logic [NUM_CH-1:0]              ch_rise;
    logic [NUM_CH-1:0]              ch_multi;
    logic [NUM_CH-1:0][COUNT_W-1:0] ch_capt;
    logic [NUM_CH-1:0]              stb_ctrl;
    logic [NUM_CH-1:0]              stb_clr;
    logic [NUM_CH-1:0]              stb_enset;
    logic [NUM_CH-1:0]              stb_enclr;
    logic [DATA_W-1:0]              rd_piece [NUM_CH];
    logic                           wdata_unused;

    assign wdata_unused = ^bus_wdata;

    // select register
    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr == ADDR_W'(EVSEL_OFS))
            st_d.evsel = bus_wdata[EVSEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch_sel = st_q.evsel;

    relay_sync2 #(.W(NUM_EVENTS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (evt_in),
        .sync_o  (ev_sync)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int A_CTRL  = chan_addr(c, OFS_CTRL);
        localparam int A_STAT  = chan_addr(c, OFS_STAT);
        localparam int A_ENSET = chan_addr(c, OFS_ENSET);
        localparam int A_ENCLR = chan_addr(c, OFS_ENCLR);
        localparam int A_CAPT  = chan_addr(c, OFS_CAPT);

        assign stb_ctrl[c]  = bus_wr && bus_addr == ADDR_W'(A_CTRL);
        assign stb_clr[c]   = bus_wr && bus_addr == ADDR_W'(A_STAT)
                              && bus_wdata[BIT_FLAG];
        assign stb_enset[c] = bus_wr && bus_addr == ADDR_W'(A_ENSET)
                              && bus_wdata[BIT_FLAG];
        assign stb_enclr[c] = bus_wr && bus_addr == ADDR_W'(A_ENCLR)
                              && bus_wdata[BIT_FLAG];

        relay_evmux #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)) u_mux (
            .ev_sync_i (ev_sync),
            .sel_i     (ch_sel[c]),
            .ev_o      (ch_ev[c])
        );

        relay_capt_chan #(.COUNT_W(COUNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_i       (ch_ev[c]),
            .ctrl_we    (stb_ctrl[c]),
            .ctrl_rise  (bus_wdata[BIT_EDGE]),
            .ctrl_multi (bus_wdata[BIT_MODE]),
            .clr_req    (stb_clr[c]),
            .enset_req  (stb_enset[c]),
            .enclr_req  (stb_enclr[c]),
            .rise_o     (ch_rise[c]),
            .multi_o    (ch_multi[c]),
            .flag_o     (ch_flag[c]),
            .en_o       (ch_en[c]),
            .fire_o     (ch_fire[c]),
            .irq_o      (irq_o[c]),
            .capt_o     (ch_capt[c])
        );

        always_comb begin
            rd_piece[c] = '0;
            if (bus_addr == ADDR_W'(A_CTRL)) begin
                rd_piece[c][BIT_EDGE] = ch_rise[c];
                rd_piece[c][BIT_MODE] = ch_multi[c];
            end else if (bus_addr == ADDR_W'(A_STAT)) begin
                rd_piece[c][BIT_FLAG] = ch_flag[c];
            end else if (bus_addr == ADDR_W'(A_ENSET) ||
                         bus_addr == ADDR_W'(A_ENCLR)) begin
                rd_piece[c][BIT_FLAG] = ch_en[c];
            end else if (bus_addr == ADDR_W'(A_CAPT)) begin
                rd_piece[c] = DATA_W'(ch_capt[c]);
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(EVSEL_OFS)) bus_rdata = DATA_W'(st_q.evsel);
        for (int c = 0; c < NUM_CH; c++) bus_rdata = bus_rdata | rd_piece[c];
    end

endmodule

// File: rtl/relay_capture_timer_chk.sv
module relay_capture_timer_chk #(
    parameter int NUM_EVENTS = 16,
    parameter int NUM_CH     = 2,
    parameter int SEL_W      = 8,
    parameter int COUNT_W    = 32
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_CH-1:0]                fire,
    input logic [NUM_CH-1:0]                flag,
    input logic [NUM_CH-1:0]                multi,
    input logic [NUM_CH-1:0]                irq,
    input logic [NUM_CH-1:0]                clr,
    input logic [NUM_CH-1:0]                enset,
    input logic [NUM_CH-1:0]                enclr,
    input logic [NUM_CH-1:0][SEL_W-1:0]     sel,
    input logic [NUM_CH-1:0][COUNT_W-1:0]   capt
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_capture_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            fire[c] |=> flag[c]);

        p_single_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[c] && !multi[c]) |=> $stable(capt[c]));

        p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[c] && !fire[c]) |=> !flag[c]);

        p_ack_race_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[c] && fire[c]) |=> flag[c]);

        p_disable_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (enclr[c] && !enset[c]) |=> !irq[c]);

        p_bad_select_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(sel[c]) >= NUM_EVENTS && int'($past(sel[c])) >= NUM_EVENTS)
            |-> !fire[c]);
    end

endmodule

bind relay_capture_timer relay_capture_timer_chk #(
    .NUM_EVENTS (NUM_EVENTS),
    .NUM_CH     (NUM_CH),
    .SEL_W      (SEL_W),
    .COUNT_W    (COUNT_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (ch_fire),
    .flag  (ch_flag),
    .multi (ch_multi),
    .irq   (irq_o),
    .clr   (stb_clr),
    .enset (stb_enset),
    .enclr (stb_enclr),
    .sel   (ch_sel),
    .capt  (ch_capt)
);

// File: tb/tb_relay_capture_timer.sv
module tb_relay_capture_timer;

    localparam int NE = 16;
    localparam int NC = 2;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NE-1:0] evt;
    logic          bus_wr;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic [NC-1:0] irq;

    always #2 clk = ~clk;

    relay_capture_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] a_of(input int ch, input int ofs);
        return 8'(16 + 32 * ch + ofs);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    typedef struct packed {
        logic       ch;
        logic [7:0] sel;
        logic [3:0] ev;
        logic       rise;
        logic       exp_r;
        logic       exp_f;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 8'd8, 4'd8, 1'b1, 1'b1, 1'b1},
        '{1'b1, 8'd9, 4'd9, 1'b1, 1'b1, 1'b1},
        '{1'b0, 8'd8, 4'd8, 1'b0, 1'b0, 1'b1},
        '{1'b1, 8'd9, 4'd9, 1'b0, 1'b0, 1'b1},
        '{1'b0, 8'd3, 4'd5, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R4 actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, a_val, b_val;
        int ch;
        rst_n = 1'b0; evt = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R12 reset state
        rd(8'h00, v);       check("R12 select reset", v, 0);
        rd(a_of(0, 0), v);  check("R12 ctrl reset", v, 0);
        rd(a_of(1, 4), v);  check("R12 status reset", v, 0);
        rd(a_of(0, 8), v);  check("R12 enable reset", v, 0);
        rd(a_of(0, 16), v); check("R12 capture reset", v, 0);
        check("R12 irq reset", 32'(irq), 0);

        // vector table: R1/R3/R4
        for (int i = 0; i < 6; i++) begin
            ch = int'(VEC[i].ch);
            wr(8'h00, VEC[i].ch ? {16'h0, VEC[i].sel, 8'hFF} : {16'h0, 8'hFF, VEC[i].sel});
            wr(a_of(ch, 0), 32'(VEC[i].rise) << 8);
            wr(a_of(ch, 8), 32'h4);
            wr(a_of(ch, 4), 32'h4);
            tick(3);
            evt[VEC[i].ev] = 1'b1;
            tick(3);
            check($sformatf("R1/R3/R4 vec%0d first edge", i), 32'(irq[ch]), 32'(VEC[i].exp_r));
            evt[VEC[i].ev] = 1'b0;
            tick(3);
            check($sformatf("R1/R3/R4 vec%0d second edge", i), 32'(irq[ch]), 32'(VEC[i].exp_f));
            wr(a_of(ch, 12), 32'h4);
            wr(a_of(ch, 4), 32'h4);
        end

        // R1 single write routes both channels
        wr(8'h00, 32'h908);
        rd(8'h00, v); check("R1 select readback", v, 32'h908);
        wr(a_of(0, 0), 32'h100); wr(a_of(1, 0), 32'h100);
        wr(a_of(0, 8), 32'h4);   wr(a_of(1, 8), 32'h4);
        wr(a_of(0, 4), 32'h4);   wr(a_of(1, 4), 32'h4);
        tick(3);
        evt[8] = 1'b1; tick(3);
        check("R1 event 8 reaches channel 0 only", 32'(irq), 32'h1);
        evt[8] = 1'b0; evt[9] = 1'b1; tick(3);
        check("R1 event 9 reaches channel 1", 32'(irq), 32'h3);
        evt[9] = 1'b0;
        wr(a_of(0, 4), 32'h4); wr(a_of(1, 4), 32'h4);
        tick(3);

        // R2 out-of-range select on channel 0
        wr(8'h00, 32'h0910);
        tick(3);
        evt = '1; tick(3);
        evt = '0; tick(3);
        rd(a_of(0, 4), v); check("R2 no capture from select 0x10", v, 0);
        check("R2 irq stays low", 32'(irq[0]), 0);
        wr(a_of(1, 4), 32'h4);

        // R6 single capture
        wr(8'h00, 32'h908);
        wr(a_of(0, 0), 32'h100);
        tick(3);
        evt[8] = 1'b1; tick(3);
        rd(a_of(0, 16), a_val);
        evt[8] = 1'b0; tick(3);
        evt[8] = 1'b1; tick(3);
        rd(a_of(0, 16), v); check("R6 capture held while flag set", v, a_val);
        rd(a_of(0, 4), v);  check("R6 flag still set", v, 32'h4);
        wr(a_of(0, 4), 32'h4);
        rd(a_of(0, 4), v);  check("R8 write-1 clears flag", v, 0);
        evt[8] = 1'b0; tick(3);
        evt[8] = 1'b1; tick(3);
        rd(a_of(0, 16), b_val);
        check("R6 new capture after clear", 32'(b_val != a_val), 1);

        // R5 level held high
        wr(a_of(0, 4), 32'h4);
        tick(6);
        rd(a_of(0, 4), v); check("R5 level does not recapture", v, 0);

        // R7 multi capture
        wr(a_of(0, 0), 32'h2100);
        evt[8] = 1'b0; tick(3);
        evt[8] = 1'b1; tick(3);
        rd(a_of(0, 16), a_val);
        evt[8] = 1'b0; tick(3);
        evt[8] = 1'b1; tick(3);
        rd(a_of(0, 16), b_val);
        check("R7 capture reloads while flag set", 32'(b_val != a_val), 1);
        rd(a_of(0, 4), v); check("R7 flag set", v, 32'h4);

        // R9 clear on the capture edge
        wr(a_of(0, 4), 32'h4);
        evt[8] = 1'b0; tick(3);
        evt[8] = 1'b1; tick(2);
        wr(a_of(0, 4), 32'h4);
        rd(a_of(0, 4), v); check("R9 capture beats clear", v, 32'h4);
        wr(a_of(0, 4), 32'h0);
        rd(a_of(0, 4), v); check("R8 write 0 keeps flag", v, 32'h4);
        wr(a_of(0, 4), 32'h4);
        rd(a_of(0, 4), v); check("R8 write 1 clears flag", v, 0);

        // R10/R11 enable
        evt[8] = 1'b0; tick(3);
        evt[8] = 1'b1; tick(3);
        check("R11 irq with flag and enable", 32'(irq[0]), 1);
        wr(a_of(0, 12), 32'h4);
        check("R10 enable-clear drops irq", 32'(irq[0]), 0);
        rd(a_of(0, 8), v);  check("R10 enable reads 0", v, 0);
        rd(a_of(0, 4), v);  check("R11 flag kept while masked", v, 32'h4);
        wr(a_of(0, 8), 32'h4);
        check("R11 irq returns with enable", 32'(irq[0]), 1);
        rd(a_of(0, 12), v); check("R10 enable reads 1", v, 32'h4);
        rd(a_of(0, 0), v);  check("R3 ctrl readback", v, 32'h2100);

        summary();
        $finish;
    end

endmodule